// File: doc/BRIEF.md
# Double-Buffer Page Flip Controller

This block sits between two frame memories, a display reader and a frame renderer. At any moment one memory is the front buffer, which the display reader scans out, and the other is the back buffer, which the renderer fills. A single select register decides which memory plays which role. A combinational crossbar routes each memory's address, write data and write enable from its current owner. It returns each memory's read data to that same owner.

The renderer reports a finished frame with a one-cycle done pulse. The display timing generator supplies an active-low blanking input: low means the screen is blanked. The block swaps the two memories only during blanking, and only after a finished frame. Every swap also issues a one-cycle capture pulse, which tells the renderer to start drawing into its newly assigned memory. A done pulse that arrives during active video is held until blanking begins. One capture is also issued right after reset, so the first frame starts without waiting for a finish.

Top module: `page_flip_top`

## Requirements
- R1: After reset is released, `sel_o` is 1. `capture_o` is high for exactly the one cycle that follows the first clock edge, and low after that.
- R2: While `sel_o` is 1, memory 0 takes its address from `disp_addr_i`, and memory 1 takes address, write data and write enable from the renderer inputs.
- R3: While `sel_o` is 0, the roles are swapped. Memory 1 takes its address from `disp_addr_i`, and memory 0 takes address, write data and write enable from the renderer.
- R4: `disp_rdata_o` returns the read data of the memory the display owns, and `rend_rdata_o` returns the read data of the memory the renderer owns. Both use the same select value that steers the addresses.
- R5: The memory owned by the display always sees write enable 0 and write data 0, whatever the renderer inputs are.
- R6: If `render_done_i` is high at a clock edge where `blank_ni` is 0, `sel_o` inverts at that edge and `capture_o` is high for the following cycle only.
- R7: `sel_o` never changes at an edge where `blank_ni` is 1. A done pulse seen during active video is remembered, and the flip happens at the first later edge where `blank_ni` is 0.
- R8: Each accepted flip produces exactly one capture pulse. Several done pulses that arrive while a flip is still pending merge into one flip. Blanking with no pending done causes no flip.
- R9: `sel_o` changes only together with a capture pulse in the following cycle, so both memories always change roles at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| render_done_i | input | 1 | Renderer finished a frame (pulse) |
| blank_ni | input | 1 | Blanking, active low (0 = blanked) |
| sel_o | output | 1 | Select bit: 1 = memory 0 is the front buffer |
| capture_o | output | 1 | One-cycle start command to the renderer |
| disp_addr_i | input | ADDR_W | Display reader address |
| disp_rdata_o | output | DATA_W | Read data to the display reader |
| rend_addr_i | input | ADDR_W | Renderer address |
| rend_wdata_i | input | DATA_W | Renderer write data |
| rend_we_i | input | 1 | Renderer write enable |
| rend_rdata_o | output | DATA_W | Read data to the renderer |
| mem_addr_o | output | 2 x ADDR_W | Address to memories 1 and 0 |
| mem_wdata_o | output | 2 x DATA_W | Write data to memories 1 and 0 |
| mem_we_o | output | 2 | Write enable to memories 1 and 0 |
| mem_rdata_i | input | 2 x DATA_W | Read data from memories 1 and 0 |

## Verification
Two events can fall in the same cycle: a done pulse and the cycle in which blanking begins. The bench raises both on the same clock edge and expects the flip and the capture at that edge, with no extra cycle spent in the pending flag. A second collision is a done pulse repeated while an earlier one is still waiting for blanking. This is judged by counting the capture pulses and expecting exactly one flip. A third case is the boot capture: it is checked that no capture follows it when no finish arrives.

// File: rtl/page_flip_pkg.sv
package page_flip_pkg;
  localparam int unsigned NUM_MEM = 2;
  typedef enum logic {OWNER_REND = 1'b0, OWNER_DISP = 1'b1} owner_e;
endpackage

// File: rtl/pf_flip_ctrl.sv
module pf_flip_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic blank_ni,
  output logic sel_o,
  output logic capture_o
);
  logic pend_q, boot_q, sel_q, cap_q;
  logic want, take;

  assign want = pend_q | done_i;
  assign take = want & ~blank_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      boot_q <= 1'b1;
      sel_q  <= 1'b1;
      cap_q  <= 1'b0;
    end else begin
      pend_q <= want & ~take;
      boot_q <= 1'b0;
      cap_q  <= take | boot_q;
      if (take) sel_q <= ~sel_q;
    end
  end

  assign sel_o     = sel_q;
  assign capture_o = cap_q;
endmodule

// File: rtl/pf_port_xbar.sv
module pf_port_xbar
  import page_flip_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 24
) (
  input  logic                            sel_i,
  input  logic [ADDR_W-1:0]               disp_addr_i,
  output logic [DATA_W-1:0]               disp_rdata_o,
  input  logic [ADDR_W-1:0]               rend_addr_i,
  input  logic [DATA_W-1:0]               rend_wdata_i,
  input  logic                            rend_we_i,
  output logic [DATA_W-1:0]               rend_rdata_o,
  output logic [NUM_MEM-1:0][ADDR_W-1:0]  mem_addr_o,
  output logic [NUM_MEM-1:0][DATA_W-1:0]  mem_wdata_o,
  output logic [NUM_MEM-1:0]              mem_we_o,
  input  logic [NUM_MEM-1:0][DATA_W-1:0]  mem_rdata_i
);
  owner_e owner [NUM_MEM];

  for (genvar i = 0; i < NUM_MEM; i++) begin : g_mem
    // memory 0 belongs to the display when sel is high
    assign owner[i] = (sel_i == (i == 0)) ? OWNER_DISP : OWNER_REND;
    assign mem_addr_o[i]  = (owner[i] == OWNER_DISP) ? disp_addr_i : rend_addr_i;
    assign mem_wdata_o[i] = (owner[i] == OWNER_DISP) ? '0 : rend_wdata_i;
    assign mem_we_o[i]    = (owner[i] == OWNER_DISP) ? 1'b0 : rend_we_i;
  end

  assign disp_rdata_o = sel_i ? mem_rdata_i[0] : mem_rdata_i[1];
  assign rend_rdata_o = sel_i ? mem_rdata_i[1] : mem_rdata_i[0];
endmodule

// File: rtl/page_flip_top.sv
module page_flip_top
  import page_flip_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 24
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            render_done_i,
  input  logic                            blank_ni,
  output logic                            sel_o,
  output logic                            capture_o,
  input  logic [ADDR_W-1:0]               disp_addr_i,
  output logic [DATA_W-1:0]               disp_rdata_o,
  input  logic [ADDR_W-1:0]               rend_addr_i,
  input  logic [DATA_W-1:0]               rend_wdata_i,
  input  logic                            rend_we_i,
  output logic [DATA_W-1:0]               rend_rdata_o,
  output logic [NUM_MEM-1:0][ADDR_W-1:0]  mem_addr_o,
  output logic [NUM_MEM-1:0][DATA_W-1:0]  mem_wdata_o,
  output logic [NUM_MEM-1:0]              mem_we_o,
  input  logic [NUM_MEM-1:0][DATA_W-1:0]  mem_rdata_i
);
  logic sel;

  pf_flip_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (render_done_i),
    .blank_ni  (blank_ni),
    .sel_o     (sel),
    .capture_o (capture_o)
  );

  pf_port_xbar #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xbar (
    .sel_i        (sel),
    .disp_addr_i  (disp_addr_i),
    .disp_rdata_o (disp_rdata_o),
    .rend_addr_i  (rend_addr_i),
    .rend_wdata_i (rend_wdata_i),
    .rend_we_i    (rend_we_i),
    .rend_rdata_o (rend_rdata_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_we_o     (mem_we_o),
    .mem_rdata_i  (mem_rdata_i)
  );

  assign sel_o = sel;
endmodule

// File: rtl/page_flip_checker.sv
module page_flip_checker
  import page_flip_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 24
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           render_done_i,
  input logic                           blank_ni,
  input logic                           sel_o,
  input logic                           capture_o,
  input logic [ADDR_W-1:0]              disp_addr_i,
  input logic [DATA_W-1:0]              disp_rdata_o,
  input logic [NUM_MEM-1:0][ADDR_W-1:0] mem_addr_o,
  input logic [NUM_MEM-1:0]             mem_we_o,
  input logic [NUM_MEM-1:0][DATA_W-1:0] mem_rdata_i
);
  assert_route_disp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> mem_addr_o[0] == disp_addr_i);
  assert_rdata_disp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |-> disp_rdata_o == mem_rdata_i[1]);
  assert_disp_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o ? !mem_we_o[0] : !mem_we_o[1]);
  assert_flip_on_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (render_done_i && !blank_ni) |=> (capture_o && sel_o != $past(sel_o)));
  assert_hold_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_ni |=> $stable(sel_o));
  assert_sel_with_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != $past(sel_o)) |-> capture_o);
endmodule

bind page_flip_top page_flip_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .render_done_i (render_done_i),
  .blank_ni      (blank_ni),
  .sel_o         (sel_o),
  .capture_o     (capture_o),
  .disp_addr_i   (disp_addr_i),
  .disp_rdata_o  (disp_rdata_o),
  .mem_addr_o    (mem_addr_o),
  .mem_we_o      (mem_we_o),
  .mem_rdata_i   (mem_rdata_i)
);

// File: tb/sim_page_flip_top.sv
`timescale 1ns/1ps
module sim_page_flip_top;
  localparam int AW = 19;
  localparam int DW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic done = 1'b0, blank_n = 1'b1;
  logic sel, cap;
  logic [AW-1:0] d_addr = '0, r_addr = '0;
  logic [DW-1:0] r_wdata = '0, d_rdata, r_rdata;
  logic r_we = 1'b0;
  logic [1:0][AW-1:0] m_addr;
  logic [1:0][DW-1:0] m_wdata, m_rdata;
  logic [1:0] m_we;
  int n_chk = 0, n_fail = 0, cap_cnt = 0;
  logic exp_sel = 1'b1;

  always #4 clk = ~clk;

  page_flip_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .render_done_i(done), .blank_ni(blank_n),
    .sel_o(sel), .capture_o(cap), .disp_addr_i(d_addr), .disp_rdata_o(d_rdata),
    .rend_addr_i(r_addr), .rend_wdata_i(r_wdata), .rend_we_i(r_we),
    .rend_rdata_o(r_rdata), .mem_addr_o(m_addr), .mem_wdata_o(m_wdata),
    .mem_we_o(m_we), .mem_rdata_i(m_rdata));

  always @(negedge clk) if (rst_n && cap) cap_cnt++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 sel in reset", sel, 1);
    chk("R1 capture in reset", cap, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 boot capture", cap, 1);
    chk("R1 sel after reset", sel, 1);
    @(negedge clk);
    chk("R1 capture drops", cap, 0);
    repeat (3) @(negedge clk);
    chk("R1 single boot capture", cap_cnt, 1);
  endtask

  task automatic t_route(input logic [AW-1:0] da, input logic [AW-1:0] ra,
                         input logic [DW-1:0] wd, input logic we);
    logic [DW-1:0] a, b;
    a = 24'hA0_0000 ^ wd;
    b = 24'h05_5555 ^ wd;
    d_addr = da; r_addr = ra; r_wdata = wd; r_we = we;
    m_rdata[0] = a; m_rdata[1] = b;
    #1;
    if (exp_sel) begin
      chk("R2 mem0 addr", m_addr[0], da);
      chk("R2 mem1 addr", m_addr[1], ra);
      chk("R2 mem1 wdata", m_wdata[1], wd);
      chk("R2 mem1 we", m_we[1], we);
      chk("R5 mem0 we", m_we[0], 0);
      chk("R5 mem0 wdata", m_wdata[0], 0);
      chk("R4 disp rdata", d_rdata, a);
      chk("R4 rend rdata", r_rdata, b);
    end else begin
      chk("R3 mem1 addr", m_addr[1], da);
      chk("R3 mem0 addr", m_addr[0], ra);
      chk("R3 mem0 wdata", m_wdata[0], wd);
      chk("R3 mem0 we", m_we[0], we);
      chk("R5 mem1 we", m_we[1], 0);
      chk("R5 mem1 wdata", m_wdata[1], 0);
      chk("R4 disp rdata", d_rdata, b);
      chk("R4 rend rdata", r_rdata, a);
    end
  endtask

  task automatic t_flip_blank();
    int c0;
    @(negedge clk);
    c0 = cap_cnt;
    done = 1'b1; blank_n = 1'b0;
    @(negedge clk);
    done = 1'b0;
    exp_sel = ~exp_sel;
    chk("R6 sel toggles", sel, exp_sel);
    chk("R6 capture high", cap, 1);
    @(negedge clk);
    chk("R6 capture one cycle", cap, 0);
    repeat (3) @(negedge clk);
    chk("R8 no flip without done", sel, exp_sel);
    chk("R8 one capture", cap_cnt - c0, 1);
    blank_n = 1'b1;
  endtask

  task automatic t_deferred(input int n_done);
    int c0;
    @(negedge clk);
    blank_n = 1'b1;
    c0 = cap_cnt;
    for (int i = 0; i < n_done; i++) begin
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R7 sel held in active video", sel, exp_sel);
    chk("R7 no capture in active video", cap_cnt - c0, 0);
    blank_n = 1'b0;
    @(negedge clk);
    exp_sel = ~exp_sel;
    chk("R7 flip at blank start", sel, exp_sel);
    chk("R7 capture at blank start", cap, 1);
    repeat (4) @(negedge clk);
    chk("R8 merged done one flip", sel, exp_sel);
    chk("R8 merged done one capture", cap_cnt - c0, 1);
    blank_n = 1'b1;
  endtask

  task automatic t_same_cycle();
    int c0;
    @(negedge clk);
    blank_n = 1'b1;
    @(negedge clk);
    c0 = cap_cnt;
    done = 1'b1; blank_n = 1'b0;
    @(negedge clk);
    done = 1'b0;
    exp_sel = ~exp_sel;
    chk("R9 sel with capture", sel, exp_sel);
    chk("R9 capture same cycle", cap, 1);
    @(negedge clk);
    chk("R9 capture single", cap, 0);
    chk("R8 same cycle one capture", cap_cnt - c0, 1);
    blank_n = 1'b1;
  endtask

  initial begin
    m_rdata = '0;
    t_reset();
    t_route(19'h1_2345, 19'h5_4321, 24'hC0FFEE, 1'b1);
    t_route(19'h7_FFFF, 19'h0_0000, 24'h123456, 1'b0);
    t_flip_blank();
    t_route(19'h0_00AA, 19'h3_3333, 24'hABCDEF, 1'b1);
    t_deferred(1);
    t_route(19'h2_0001, 19'h6_0F0F, 24'h0F0F0F, 1'b1);
    t_deferred(3);
    t_same_cycle();
    t_route(19'h4_4444, 19'h1_1111, 24'hFEDCBA, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule